// File: doc/BRIEF.md
# Receiver Error Concealment Controller

This block follows the biphase decoder of a digital audio interface receiver. For each decoded frame it receives the audio sample, the parity-check result, the incoming validity bit and sampling-rate code, and a frame strobe. It also receives a level that reports loss of lock, which upstream logic derives from failed preamble detection. From these inputs it produces the sample to pass downstream, a validity output, a sampling-rate code output and an error flag.

Concealment is graded by severity. A short run of frames with bad parity repeats the last sample that passed parity. A run longer than `RUN_LIMIT` frames mutes the output to zero. Loss of lock mutes the output, clears the validity output and forces the sampling-rate code to a fixed "unlocked" value. The error flag rises on any fault. It falls only after `HOLD_FRAMES` consecutive clean frames, so the hold-off time is a frame count and shrinks as the sampling rate rises. The default of 12000 frames gives roughly a quarter of a second at common audio rates.

Top module: `rx_conceal_top`

## Requirements
- R1: After reset, sampleOut is 0, vflagOut is 0, rateCodeOut equals LOCK_CODE (default 4'b0001) and errorFlag is 1.
- R2: On a frame strobe with parityOk=1 and lockErr=0, the next clock edge loads sampleIn, vflagIn and rateCodeIn into sampleOut, vflagOut and rateCodeOut.
- R3: For bad-parity frames (frameValid=1, parityOk=0, lockErr=0) that are the 1st through RUN_LIMIT-th (default 8) in a row, sampleOut repeats the last good sample, rateCodeOut keeps its value and vflagOut follows vflagIn.
- R4: From the (RUN_LIMIT+1)-th consecutive bad-parity frame onward, sampleOut is 0. rateCodeOut and vflagOut still behave as in R3.
- R5: A good-parity frame resets the consecutive-error run to zero and becomes the new held sample.
- R6: While lockErr=1, on any cycle and whether or not a strobe is present, the next edge gives sampleOut=0, vflagOut=0, rateCodeOut=LOCK_CODE and errorFlag=1. It also clears the held sample to 0 and the error run.
- R7: A bad-parity frame or lockErr sets errorFlag at the next edge.
- R8: errorFlag falls at the edge of the HOLD_FRAMES-th consecutive good frame after the last fault. A bad-parity frame or lockErr during that window restarts the count.
- R9: With frameValid=0 and lockErr=0, sampleOut, vflagOut, rateCodeOut and errorFlag keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameValid | input | 1 | One-cycle strobe marking a decoded frame |
| sampleIn | input | W | Decoded audio sample |
| parityOk | input | 1 | 1 when the frame passed its parity check |
| vflagIn | input | 1 | Validity bit decoded from the frame |
| rateCodeIn | input | RATE_W | Sampling-rate code from the rate detector |
| lockErr | input | 1 | Level, 1 while preamble detection reports loss of lock |
| sampleOut | output | W | Concealed audio sample |
| vflagOut | output | 1 | Validity output |
| rateCodeOut | output | RATE_W | Sampling-rate code output |
| errorFlag | output | 1 | Error indication with recovery hold-off |

## Verification
The assertions assume that every input is at a known value after reset and that a frame strobe lasts one cycle. They also assume that lockErr is a level that may change in any cycle, not only on strobes. The stimulus changes inputs only on the falling clock edge. It sends frames back to back or with idle gaps in which sampleIn, vflagIn and rateCodeIn move deliberately, and it raises lockErr both with and without a strobe. The bench reduces HOLD_FRAMES to 4 so that the hold-off expiry and its restart can be reached in a few frames.

// File: rtl/conceal_pkg.sv
package conceal_pkg;
  // Per-cycle commands from control to datapath
  typedef struct packed {
    logic clear;    // lock lost: mute, clear validity, force unlocked rate code
    logic load;     // good frame: pass through and capture as held sample
    logic conceal;  // bad-parity frame: substitute held or muted sample
    logic mute;     // with conceal: run is past the hold limit
  } strobe_t;
endpackage

// File: rtl/conceal_ctrl.sv
module conceal_ctrl
  import conceal_pkg::*;
#(
  parameter int RUN_LIMIT   = 8,
  parameter int HOLD_FRAMES = 12000
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    frameValid,
  input  logic    parityOk,
  input  logic    lockErr,
  output strobe_t st,
  output logic    errorFlag
);
  localparam int RUN_W  = $clog2(RUN_LIMIT + 1);
  localparam int HOLD_W = $clog2(HOLD_FRAMES + 1);
  localparam logic [RUN_W-1:0]  RUN_MAX  = RUN_W'(RUN_LIMIT);
  localparam logic [HOLD_W-1:0] HOLD_END = HOLD_W'(HOLD_FRAMES - 1);

  logic [RUN_W-1:0]  runCnt;
  logic [HOLD_W-1:0] holdCnt;
  logic frameGood, frameBad;

  assign frameGood = frameValid && !lockErr && parityOk;
  assign frameBad  = frameValid && !lockErr && !parityOk;

  always_comb begin
    st.clear   = lockErr;
    st.load    = frameGood;
    st.conceal = frameBad;
    st.mute    = frameBad && (runCnt == RUN_MAX);
  end

  // Consecutive bad-parity run, saturating at RUN_LIMIT
  always_ff @(posedge clk) begin
    if (!rstN || lockErr || frameGood) begin
      runCnt <= '0;
    end else if (frameBad && runCnt != RUN_MAX) begin
      runCnt <= runCnt + 1'b1;
    end
  end

  // Error flag with a hold-off counted in clean frames
  always_ff @(posedge clk) begin
    if (!rstN) begin
      errorFlag <= 1'b1;
      holdCnt   <= '0;
    end else if (lockErr || frameBad) begin
      errorFlag <= 1'b1;
      holdCnt   <= '0;
    end else if (frameGood && errorFlag) begin
      if (holdCnt == HOLD_END) begin
        errorFlag <= 1'b0;
        holdCnt   <= '0;
      end else begin
        holdCnt <= holdCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/conceal_datapath.sv
module conceal_datapath
  import conceal_pkg::*;
#(
  parameter int          W         = 16,
  parameter int          RATE_W    = 4,
  parameter logic [RATE_W-1:0] LOCK_CODE = 4'b0001
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  input  logic [W-1:0]      sampleIn,
  input  logic              vflagIn,
  input  logic [RATE_W-1:0] rateCodeIn,
  output logic [W-1:0]      sampleOut,
  output logic              vflagOut,
  output logic [RATE_W-1:0] rateCodeOut
);
  logic [W-1:0] heldSample;

  always_ff @(posedge clk) begin
    if (!rstN || st.clear) begin
      sampleOut   <= '0;
      heldSample  <= '0;
      vflagOut    <= 1'b0;
      rateCodeOut <= LOCK_CODE;
    end else if (st.load) begin
      sampleOut   <= sampleIn;
      heldSample  <= sampleIn;
      vflagOut    <= vflagIn;
      rateCodeOut <= rateCodeIn;
    end else if (st.conceal) begin
      sampleOut <= st.mute ? '0 : heldSample;
      vflagOut  <= vflagIn;
    end
  end
endmodule

// File: rtl/rx_conceal_top.sv
module rx_conceal_top
  import conceal_pkg::*;
#(
  parameter int          W           = 16,
  parameter int          RATE_W      = 4,
  parameter int          RUN_LIMIT   = 8,
  parameter int          HOLD_FRAMES = 12000,
  parameter logic [RATE_W-1:0] LOCK_CODE = 4'b0001
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameValid,
  input  logic [W-1:0]      sampleIn,
  input  logic              parityOk,
  input  logic              vflagIn,
  input  logic [RATE_W-1:0] rateCodeIn,
  input  logic              lockErr,
  output logic [W-1:0]      sampleOut,
  output logic              vflagOut,
  output logic [RATE_W-1:0] rateCodeOut,
  output logic              errorFlag
);
  strobe_t st;

  conceal_ctrl #(
    .RUN_LIMIT  (RUN_LIMIT),
    .HOLD_FRAMES(HOLD_FRAMES)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .frameValid(frameValid),
    .parityOk  (parityOk),
    .lockErr   (lockErr),
    .st        (st),
    .errorFlag (errorFlag)
  );

  conceal_datapath #(
    .W        (W),
    .RATE_W   (RATE_W),
    .LOCK_CODE(LOCK_CODE)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .st         (st),
    .sampleIn   (sampleIn),
    .vflagIn    (vflagIn),
    .rateCodeIn (rateCodeIn),
    .sampleOut  (sampleOut),
    .vflagOut   (vflagOut),
    .rateCodeOut(rateCodeOut)
  );
endmodule

// File: rtl/rx_conceal_chk.sv
module rx_conceal_chk #(
  parameter int          W         = 16,
  parameter int          RATE_W    = 4,
  parameter int          RUN_LIMIT = 8,
  parameter logic [RATE_W-1:0] LOCK_CODE = 4'b0001
) (
  input logic              clk,
  input logic              rstN,
  input logic              frameValid,
  input logic [W-1:0]      sampleIn,
  input logic              parityOk,
  input logic              vflagIn,
  input logic [RATE_W-1:0] rateCodeIn,
  input logic              lockErr,
  input logic [W-1:0]      sampleOut,
  input logic              vflagOut,
  input logic [RATE_W-1:0] rateCodeOut,
  input logic              errorFlag
);
  localparam int RUN_W = $clog2(RUN_LIMIT + 2);

  logic good, bad;
  logic [RUN_W-1:0] badRun;  // independent count of consecutive bad frames
  assign good = frameValid && !lockErr && parityOk;
  assign bad  = frameValid && !lockErr && !parityOk;

  always_ff @(posedge clk) begin
    if (!rstN || lockErr || good) badRun <= '0;
    else if (bad && badRun != RUN_W'(RUN_LIMIT + 1)) badRun <= badRun + 1'b1;
  end

  a_r2_pass_through: assert property (@(posedge clk) disable iff (!rstN)
    good |=> (sampleOut == $past(sampleIn)) && (vflagOut == $past(vflagIn))
             && (rateCodeOut == $past(rateCodeIn)));

  a_r3_rate_kept: assert property (@(posedge clk) disable iff (!rstN)
    bad |=> (rateCodeOut == $past(rateCodeOut)) && (vflagOut == $past(vflagIn)));

  a_r4_mute_long_run: assert property (@(posedge clk) disable iff (!rstN)
    (bad && badRun >= RUN_W'(RUN_LIMIT)) |=> (sampleOut == '0));

  a_r6_lock_clear: assert property (@(posedge clk) disable iff (!rstN)
    lockErr |=> (sampleOut == '0) && !vflagOut && (rateCodeOut == LOCK_CODE) && errorFlag);

  a_r7_error_rise: assert property (@(posedge clk) disable iff (!rstN)
    bad |=> errorFlag);

  a_r8_fall_on_good: assert property (@(posedge clk) disable iff (!rstN)
    $fell(errorFlag) |-> $past(good));

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!frameValid && !lockErr) |=> $stable(sampleOut) && $stable(vflagOut)
                                  && $stable(rateCodeOut) && $stable(errorFlag));
endmodule

bind rx_conceal_top rx_conceal_chk #(
  .W(W), .RATE_W(RATE_W), .RUN_LIMIT(RUN_LIMIT), .LOCK_CODE(LOCK_CODE)
) u_chk (
  .clk(clk), .rstN(rstN), .frameValid(frameValid), .sampleIn(sampleIn),
  .parityOk(parityOk), .vflagIn(vflagIn), .rateCodeIn(rateCodeIn),
  .lockErr(lockErr), .sampleOut(sampleOut), .vflagOut(vflagOut),
  .rateCodeOut(rateCodeOut), .errorFlag(errorFlag)
);

// File: tb/tb_rx_conceal_top.sv
module tb_rx_conceal_top;
  localparam int W = 16;
  localparam int RATE_W = 4;
  localparam int RUN_LIMIT = 8;
  localparam int HOLD = 4;
  localparam logic [3:0] LOCKC = 4'b0001;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameValid = 1'b0, parityOk = 1'b1, vflagIn = 1'b0, lockErr = 1'b0;
  logic [W-1:0] sampleIn = '0;
  logic [RATE_W-1:0] rateCodeIn = '0;
  logic [W-1:0] sampleOut;
  logic vflagOut, errorFlag;
  logic [RATE_W-1:0] rateCodeOut;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;  // 250 MHz

  rx_conceal_top #(
    .W(W), .RATE_W(RATE_W), .RUN_LIMIT(RUN_LIMIT),
    .HOLD_FRAMES(HOLD), .LOCK_CODE(LOCKC)
  ) dut (
    .clk(clk), .rstN(rstN), .frameValid(frameValid), .sampleIn(sampleIn),
    .parityOk(parityOk), .vflagIn(vflagIn), .rateCodeIn(rateCodeIn),
    .lockErr(lockErr), .sampleOut(sampleOut), .vflagOut(vflagOut),
    .rateCodeOut(rateCodeOut), .errorFlag(errorFlag)
  );

  typedef struct packed {
    logic       lock;
    logic       par;
    logic       v;
    logic [3:0] rate;
    logic [15:0] smp;
    logic [15:0] eSmp;
    logic       eErr;
    logic       eV;
    logic [3:0] eRate;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [0:NV-1] = '{
    '{1'b0, 1'b1, 1'b1, 4'h3, 16'h1111, 16'h1111, 1'b1, 1'b1, 4'h3},
    '{1'b0, 1'b1, 1'b0, 4'h3, 16'h2222, 16'h2222, 1'b1, 1'b0, 4'h3},
    '{1'b0, 1'b1, 1'b1, 4'h3, 16'h3333, 16'h3333, 1'b1, 1'b1, 4'h3},
    '{1'b0, 1'b1, 1'b1, 4'h3, 16'h4444, 16'h4444, 1'b0, 1'b1, 4'h3},
    '{1'b0, 1'b0, 1'b1, 4'h5, 16'hAAAA, 16'h4444, 1'b1, 1'b1, 4'h3},
    '{1'b0, 1'b0, 1'b0, 4'h5, 16'hBBBB, 16'h4444, 1'b1, 1'b0, 4'h3},
    '{1'b0, 1'b1, 1'b1, 4'h6, 16'h5555, 16'h5555, 1'b1, 1'b1, 4'h6},
    '{1'b0, 1'b1, 1'b1, 4'h6, 16'h6666, 16'h6666, 1'b1, 1'b1, 4'h6},
    '{1'b1, 1'b1, 1'b1, 4'h6, 16'h7777, 16'h0000, 1'b1, 1'b0, 4'h1},
    '{1'b0, 1'b0, 1'b1, 4'h6, 16'h8888, 16'h0000, 1'b1, 1'b1, 4'h1},
    '{1'b0, 1'b1, 1'b1, 4'h7, 16'h9999, 16'h9999, 1'b1, 1'b1, 4'h7}
  };

  task automatic checkAll(input string req, input logic [W-1:0] eS,
                          input logic eE, input logic eV, input logic [3:0] eR);
    checks++;
    if (sampleOut !== eS || errorFlag !== eE || vflagOut !== eV || rateCodeOut !== eR) begin
      fails++;
      $display("FAIL %s: got smp=%h err=%b v=%b rate=%h, expected smp=%h err=%b v=%b rate=%h",
               req, sampleOut, errorFlag, vflagOut, rateCodeOut, eS, eE, eV, eR);
    end
  endtask

  // Drive one cycle at the falling edge; outputs are read one edge later
  task automatic step(input logic fv, input logic lk, input logic pr, input logic v,
                      input logic [3:0] r, input logic [W-1:0] s);
    frameValid = fv; lockErr = lk; parityOk = pr; vflagIn = v;
    rateCodeIn = r; sampleIn = s;
    @(negedge clk);
    frameValid = 1'b0; lockErr = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    checkAll("R1 reset", '0, 1'b1, 1'b0, LOCKC);
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1 after release", '0, 1'b1, 1'b0, LOCKC);

    // Vector table: R2 R3 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      step(1'b1, VECS[i].lock, VECS[i].par, VECS[i].v, VECS[i].rate, VECS[i].smp);
      checkAll($sformatf("R2/R3/R6/R7/R8 vec %0d", i),
               VECS[i].eSmp, VECS[i].eErr, VECS[i].eV, VECS[i].eRate);
    end

    // R9: idle cycles with moving inputs change nothing
    for (int i = 0; i < 3; i++) begin
      step(1'b0, 1'b0, i[0], i[1], 4'(i + 9), 16'(16'hC000 + i));
      checkAll("R9 idle", 16'h9999, 1'b1, 1'b1, 4'h7);
    end

    // R8: hold-off restart. Three good frames (one already counted), then bad
    step(1'b1, 1'b0, 1'b1, 1'b1, 4'h7, 16'h1234);
    step(1'b1, 1'b0, 1'b1, 1'b1, 4'h7, 16'h1235);
    checkAll("R8 before expiry", 16'h1235, 1'b1, 1'b1, 4'h7);
    step(1'b1, 1'b0, 1'b0, 1'b0, 4'h2, 16'hDEAD);
    checkAll("R7 R3 bad restarts", 16'h1235, 1'b1, 1'b0, 4'h7);
    for (int i = 0; i < HOLD - 1; i++) begin
      step(1'b1, 1'b0, 1'b1, 1'b1, 4'h8, 16'(16'h2000 + i));
      checkAll("R8 restarted count", 16'(16'h2000 + i), 1'b1, 1'b1, 4'h8);
    end
    step(1'b1, 1'b0, 1'b1, 1'b1, 4'h8, 16'h2FFF);
    checkAll("R8 expiry", 16'h2FFF, 1'b0, 1'b1, 4'h8);

    // R3/R4: long bad run
    for (int i = 1; i <= RUN_LIMIT + 2; i++) begin
      step(1'b1, 1'b0, 1'b0, i[0], 4'hE, 16'hBEEF);
      if (i <= RUN_LIMIT) checkAll($sformatf("R3 hold run %0d", i), 16'h2FFF, 1'b1, i[0], 4'h8);
      else checkAll($sformatf("R4 mute run %0d", i), '0, 1'b1, i[0], 4'h8);
    end

    // R5: good frame resets run; a new run of RUN_LIMIT holds again
    step(1'b1, 1'b0, 1'b1, 1'b1, 4'h9, 16'h7A7A);
    checkAll("R5 good after mute", 16'h7A7A, 1'b1, 1'b1, 4'h9);
    for (int i = 1; i <= RUN_LIMIT; i++) begin
      step(1'b1, 1'b0, 1'b0, 1'b1, 4'h3, 16'h0BAD);
    end
    checkAll("R5 run restarted", 16'h7A7A, 1'b1, 1'b1, 4'h9);

    // R6: lock error with no strobe still clears
    step(1'b0, 1'b1, 1'b1, 1'b1, 4'h9, 16'h5A5A);
    checkAll("R6 lock no strobe", '0, 1'b1, 1'b0, LOCKC);

    // R1: reset mid-stream
    step(1'b1, 1'b0, 1'b1, 1'b1, 4'h4, 16'h4321);
    rstN = 1'b0;
    @(negedge clk);
    checkAll("R1 reapplied", '0, 1'b1, 1'b0, LOCKC);
    rstN = 1'b1;

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule